// File: doc/BRIEF.md
# SDRAM Bank Auto-Precharge Tracker

This block follows the life cycle of a single SDRAM bank from the command stream that a memory controller sends to it, or that a protocol monitor observes. Each clock it takes one decoded command, the address bit that asks for auto-precharge, and the programmed burst settings. It reports whether the bank is idle, open, finishing an auto-precharge access, or recovering from precharge. It shows when a new activate is legal and raises one-cycle flags for commands that break the auto-precharge rules.

A read or write that carries the auto-precharge request moves the bank into a locked burst phase. The bank then closes by itself at the point where an explicit precharge could first have been issued: for reads, as many clocks after the command as the burst is long; for writes, the data-in-to-precharge time after the last write data beat. The row-precharge recovery time follows. Bursts without the request stay open and can be cut short. The block also marks the clocks in which read data shows at the module pins. On a registered module that is one clock later than the bare CAS latency.

Top module: `bank_ap_tracker`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the bank in IDLE (`bankState` 0) with `actAllowed` high and `bankOpen`, `precharging`, `apViolation`, `actViolation` and `rdDataValid` low.
- R2: Command codes on `cmdIn` are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 burst stop (6 and 7 act as no-op). State codes on `bankState` are 0 IDLE, 1 ACTIVE, 2 BURST_AP, 3 PRECHARGING. An activate in IDLE makes the state ACTIVE from the next clock.
- R3: A read or write in ACTIVE with `apReq` low leaves the bank ACTIVE during and after its burst.
- R4: A read in ACTIVE with `apReq` high and burst length BL (`burstSel` 0,1,2,3 selects 1,2,4,8) gives BURST_AP in the BL-1 clocks after the command and PRECHARGING from clock BL after it (clock 2 for BL 2). With BL 1 the state goes straight to PRECHARGING.
- R5: A write in ACTIVE with `apReq` high gives PRECHARGING starting T_DPL clocks after the last write data clock. The data clocks run from the command clock for BL clocks, or for one clock when `wrSingle` is high. The clocks in between are BURST_AP.
- R6: PRECHARGING lasts exactly T_RP clocks and is followed by IDLE, the only state with `actAllowed` high.
- R7: A precharge command in ACTIVE gives PRECHARGING from the next clock, for T_RP clocks.
- R8: A read, write, precharge or burst stop presented in BURST_AP sets `apViolation` for the next clock and is otherwise ignored: the state and the read data window are unchanged.
- R9: Without auto-precharge, a later read, write, precharge or burst stop in ACTIVE ends the read burst in progress. A read starts a new burst.
- R10: With `burstSel` 4 (full page, whether or not `wrSingle` is high), `apReq` is ignored and the bank stays ACTIVE. A full-page read delivers data every clock until a read, write, precharge or burst stop ends it.
- R11: An activate presented in any state other than IDLE sets `actViolation` for the next clock and does not change the state.
- R12: Each clock of an accepted read burst gives `rdDataValid` high exactly `casLat`+1 clocks later (supported `casLat` 1 to 3).
- R13: Reads, writes, precharges and burst stops in IDLE or PRECHARGING are ignored and raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmdIn | input | 3 | Decoded command of this clock |
| apReq | input | 1 | Auto-precharge request bit sent with read or write |
| burstSel | input | 3 | Burst length code: 0..3 give 1,2,4,8; 4 gives full page |
| wrSingle | input | 1 | Writes are single beats (burst applies to reads only) |
| casLat | input | CL_W | CAS latency in clocks |
| bankState | output | 2 | Bank state code |
| bankOpen | output | 1 | Row is open (ACTIVE or BURST_AP) |
| precharging | output | 1 | Precharge recovery in progress |
| actAllowed | output | 1 | An activate would be accepted now |
| apViolation | output | 1 | Previous command interrupted an auto-precharge burst |
| actViolation | output | 1 | Previous command was an activate the bank could not take |
| rdDataValid | output | 1 | Read data present at the module pins this clock |

## Verification
The bank state is brought straight out, so a wrong transition shows at the ports on the very next clock. A recovery or burst counter that is off by one moves the edge of `precharging` or `actAllowed` by one clock. A fault in the read beat counter appears on `rdDataValid` only `casLat`+1 clocks after the faulty beat. The bench therefore compares every output on every clock against a behavioural model. Directed checks sit on the exact clocks where precharge starts and where activation becomes legal again.

// File: rtl/bank_ap_pkg.sv
package bank_ap_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_BST = 3'd5
  } cmdT;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_ACTIVE   = 2'd1,
    ST_BURST_AP = 2'd2,
    ST_PRECH    = 2'd3
  } bankStateT;

  localparam logic [2:0] BURST_FULL_CODE = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAp;     // load the auto-precharge wait
    logic apIsWrite;  // the access being loaded is a write
    logic loadRp;     // load the precharge recovery time
    logic decTimer;   // count the shared timer down
    logic rdStart;    // accepted read starts a burst
    logic rdCut;      // accepted command ends the read burst
  } ctrlStrobeT;

endpackage

// File: rtl/bank_ap_dp.sv
module bank_ap_dp
  import bank_ap_pkg::*;
#(
  parameter int T_RP   = 3,
  parameter int T_DPL  = 1,
  parameter int MAX_CL = 3,
  localparam int CL_W  = $clog2(MAX_CL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobeT       strobe,
  input  logic [2:0]       burstSel,
  input  logic             wrSingle,
  input  logic [CL_W-1:0]  casLat,
  output logic             apShortRd,
  output logic             apShortWr,
  output logic             timerLast,
  output logic             fullPage,
  output logic             rdDataValid
);

  localparam int MAX_BURST   = 8;
  localparam int MAX_AP_WAIT = MAX_BURST + T_DPL;
  localparam int TIMER_MAX   = (MAX_AP_WAIT > T_RP) ? MAX_AP_WAIT : T_RP;
  localparam int TIMER_W     = $clog2(TIMER_MAX + 1);

  logic [TIMER_W-1:0] blRd, blWr, apLenRd, apLenWr;
  logic [TIMER_W-1:0] timerQ, rdLeftQ;
  logic               rdFullQ, beatNow;
  logic [MAX_CL:0]    pipeQ;

  // burst length decode
  always_comb begin
    case (burstSel)
      3'd1:    blRd = TIMER_W'(2);
      3'd2:    blRd = TIMER_W'(4);
      3'd3:    blRd = TIMER_W'(8);
      default: blRd = TIMER_W'(1);
    endcase
  end

  assign fullPage = (burstSel == BURST_FULL_CODE);
  assign blWr     = wrSingle ? TIMER_W'(1) : blRd;

  // clocks spent in BURST_AP after the command clock
  assign apLenRd   = blRd - TIMER_W'(1);
  assign apLenWr   = blWr + TIMER_W'(T_DPL) - TIMER_W'(2);
  assign apShortRd = (apLenRd == '0);
  assign apShortWr = (apLenWr == '0);

  // shared down counter: auto-precharge wait, then recovery
  always_ff @(posedge clk) begin
    if (rst) begin
      timerQ <= '0;
    end else if (strobe.loadAp) begin
      timerQ <= strobe.apIsWrite ? apLenWr : apLenRd;
    end else if (strobe.loadRp) begin
      timerQ <= TIMER_W'(T_RP);
    end else if (strobe.decTimer) begin
      timerQ <= timerQ - TIMER_W'(1);
    end
  end

  assign timerLast = (timerQ == TIMER_W'(1));

  // read beat tracking at the device
  assign beatNow = strobe.rdStart |
                   (~strobe.rdCut & (rdFullQ | (rdLeftQ != '0)));

  always_ff @(posedge clk) begin
    if (rst) begin
      rdLeftQ <= '0;
      rdFullQ <= 1'b0;
    end else if (strobe.rdStart) begin
      rdFullQ <= fullPage;
      rdLeftQ <= fullPage ? '0 : (blRd - TIMER_W'(1));
    end else if (strobe.rdCut) begin
      rdLeftQ <= '0;
      rdFullQ <= 1'b0;
    end else if (rdLeftQ != '0) begin
      rdLeftQ <= rdLeftQ - TIMER_W'(1);
    end
  end

  // latency line: stage k holds the beat of k+1 clocks ago
  always_ff @(posedge clk) begin
    if (rst) begin
      pipeQ <= '0;
    end else begin
      pipeQ[0] <= beatNow;
      for (int i = 1; i <= MAX_CL; i++) begin
        pipeQ[i] <= pipeQ[i-1];
      end
    end
  end

  assign rdDataValid = pipeQ[casLat];

endmodule

// File: rtl/bank_ap_ctrl.sv
module bank_ap_ctrl
  import bank_ap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  cmdT        cmd,
  input  logic       apReq,
  input  logic       apShortRd,
  input  logic       apShortWr,
  input  logic       timerLast,
  input  logic       fullPage,
  output ctrlStrobeT strobe,
  output bankStateT  stateQ,
  output logic       bankOpen,
  output logic       precharging,
  output logic       actAllowed,
  output logic       apViolation,
  output logic       actViolation
);

  bankStateT stateNext;
  logic      apViolNext, actViolNext, apTaken, apShort, isAccess;

  assign apTaken  = apReq & ~fullPage;
  assign isAccess = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign apShort  = (cmd == CMD_WR) ? apShortWr : apShortRd;

  always_comb begin
    stateNext   = stateQ;
    strobe      = '0;
    apViolNext  = 1'b0;
    actViolNext = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (cmd == CMD_ACT) stateNext = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (cmd == CMD_ACT) actViolNext = 1'b1;
        if (isAccess) begin
          strobe.rdStart   = (cmd == CMD_RD);
          strobe.rdCut     = (cmd == CMD_WR);
          strobe.apIsWrite = (cmd == CMD_WR);
          if (apTaken) begin
            if (apShort) begin
              stateNext     = ST_PRECH;
              strobe.loadRp = 1'b1;
            end else begin
              stateNext     = ST_BURST_AP;
              strobe.loadAp = 1'b1;
            end
          end
        end
        if (cmd == CMD_PRE) begin
          stateNext     = ST_PRECH;
          strobe.loadRp = 1'b1;
          strobe.rdCut  = 1'b1;
        end
        if (cmd == CMD_BST) strobe.rdCut = 1'b1;
      end
      ST_BURST_AP: begin
        if (isAccess || cmd == CMD_PRE || cmd == CMD_BST) apViolNext = 1'b1;
        if (cmd == CMD_ACT) actViolNext = 1'b1;
        if (timerLast) begin
          stateNext     = ST_PRECH;
          strobe.loadRp = 1'b1;
        end else begin
          strobe.decTimer = 1'b1;
        end
      end
      ST_PRECH: begin
        if (cmd == CMD_ACT) actViolNext = 1'b1;
        if (timerLast) stateNext = ST_IDLE;
        else           strobe.decTimer = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ       <= ST_IDLE;
      apViolation  <= 1'b0;
      actViolation <= 1'b0;
    end else begin
      stateQ       <= stateNext;
      apViolation  <= apViolNext;
      actViolation <= actViolNext;
    end
  end

  assign bankOpen    = (stateQ == ST_ACTIVE) || (stateQ == ST_BURST_AP);
  assign precharging = (stateQ == ST_PRECH);
  assign actAllowed  = (stateQ == ST_IDLE);

endmodule

// File: rtl/bank_ap_tracker.sv
module bank_ap_tracker
  import bank_ap_pkg::*;
#(
  parameter int T_RP   = 3,
  parameter int T_DPL  = 1,
  parameter int MAX_CL = 3,
  localparam int CL_W  = $clog2(MAX_CL + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      cmdIn,
  input  logic            apReq,
  input  logic [2:0]      burstSel,
  input  logic            wrSingle,
  input  logic [CL_W-1:0] casLat,
  output logic [1:0]      bankState,
  output logic            bankOpen,
  output logic            precharging,
  output logic            actAllowed,
  output logic            apViolation,
  output logic            actViolation,
  output logic            rdDataValid
);

  ctrlStrobeT strobe;
  bankStateT  stateQ;
  logic       apShortRd, apShortWr, timerLast, fullPage;

  bank_ap_ctrl uCtrl (
    .clk          (clk),
    .rst          (rst),
    .cmd          (cmdT'(cmdIn)),
    .apReq        (apReq),
    .apShortRd    (apShortRd),
    .apShortWr    (apShortWr),
    .timerLast    (timerLast),
    .fullPage     (fullPage),
    .strobe       (strobe),
    .stateQ       (stateQ),
    .bankOpen     (bankOpen),
    .precharging  (precharging),
    .actAllowed   (actAllowed),
    .apViolation  (apViolation),
    .actViolation (actViolation)
  );

  bank_ap_dp #(
    .T_RP   (T_RP),
    .T_DPL  (T_DPL),
    .MAX_CL (MAX_CL)
  ) uDp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .burstSel    (burstSel),
    .wrSingle    (wrSingle),
    .casLat      (casLat),
    .apShortRd   (apShortRd),
    .apShortWr   (apShortWr),
    .timerLast   (timerLast),
    .fullPage    (fullPage),
    .rdDataValid (rdDataValid)
  );

  assign bankState = stateQ;

endmodule

// File: rtl/bank_ap_checker.sv
module bank_ap_checker
  import bank_ap_pkg::*;
#(
  parameter int T_RP = 3
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] cmdIn,
  input logic       apReq,
  input logic [2:0] burstSel,
  input logic [1:0] bankState,
  input logic       precharging,
  input logic       actAllowed,
  input logic       apViolation,
  input logic       actViolation
);

  int precRun;

  always_ff @(posedge clk) begin
    if (rst)              precRun <= 0;
    else if (precharging) precRun <= precRun + 1;
    else                  precRun <= 0;
  end

  assert_open_from_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (bankState == 2'd0 && cmdIn == 3'd1) |=> bankState == 2'd1);

  assert_plain_stays_open_R3: assert property (@(posedge clk) disable iff (rst)
    (bankState == 2'd1 && (cmdIn == 3'd2 || cmdIn == 3'd3) && !apReq) |=> bankState == 2'd1);

  assert_ap_exit_path_R4: assert property (@(posedge clk) disable iff (rst)
    (bankState == 2'd2) |=> (bankState == 2'd2 || bankState == 2'd3));

  assert_recovery_length_R6: assert property (@(posedge clk) disable iff (rst)
    (actAllowed && $past(precharging)) |-> precRun == T_RP);

  assert_pre_closes_R7: assert property (@(posedge clk) disable iff (rst)
    (bankState == 2'd1 && cmdIn == 3'd4) |=> bankState == 2'd3);

  assert_ap_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (bankState == 2'd2 && cmdIn >= 3'd2 && cmdIn <= 3'd5) |=> apViolation);

  assert_fullpage_open_R10: assert property (@(posedge clk) disable iff (rst)
    (bankState == 2'd1 && (cmdIn == 3'd2 || cmdIn == 3'd3) && burstSel == BURST_FULL_CODE)
      |=> bankState == 2'd1);

  assert_act_refused_R11: assert property (@(posedge clk) disable iff (rst)
    (bankState != 2'd0 && cmdIn == 3'd1) |=> actViolation);

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (rst)
    (bankState == 2'd0 && cmdIn != 3'd1) |=> (bankState == 2'd0 && !apViolation && !actViolation));

endmodule

bind bank_ap_tracker bank_ap_checker #(.T_RP(T_RP)) uChk (
  .clk          (clk),
  .rst          (rst),
  .cmdIn        (cmdIn),
  .apReq        (apReq),
  .burstSel     (burstSel),
  .bankState    (bankState),
  .precharging  (precharging),
  .actAllowed   (actAllowed),
  .apViolation  (apViolation),
  .actViolation (actViolation)
);

// File: tb/bank_ap_tracker_bench.sv
module bank_ap_tracker_bench;

  localparam int CLK_PERIOD = 10;
  localparam int T_RP  = 3;
  localparam int T_DPL = 2;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4, BST = 3'd5;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] cmdIn;
  logic       apReq;
  logic [2:0] burstSel;
  logic       wrSingle;
  logic [1:0] casLat;
  logic [1:0] bankState;
  logic       bankOpen, precharging, actAllowed, apViolation, actViolation, rdDataValid;

  int    errs = 0;
  int    total = 0;
  string curReq = "R1";
  bit    checking = 0;
  bit    done = 0;

  bank_ap_tracker #(.T_RP(T_RP), .T_DPL(T_DPL), .MAX_CL(3)) u_bank_ap_tracker (
    .clk(clk), .rst(rst), .cmdIn(cmdIn), .apReq(apReq), .burstSel(burstSel),
    .wrSingle(wrSingle), .casLat(casLat), .bankState(bankState), .bankOpen(bankOpen),
    .precharging(precharging), .actAllowed(actAllowed), .apViolation(apViolation),
    .actViolation(actViolation), .rdDataValid(rdDataValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int cyc = 0;
  int mState = 0;
  int precAt = 0, idleAt = 0, beatEnd = -1;
  bit mApV = 0, mActV = 0;
  bit dvAt[int];
  int bl, blw, len;
  bit beat, full;

  function automatic int blOf(logic [2:0] code);
    case (code)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mState = 0; mApV = 0; mActV = 0; beatEnd = -1;
      dvAt.delete();
    end else begin
      bl   = blOf(burstSel);
      blw  = wrSingle ? 1 : bl;
      full = (burstSel == 3'd4);
      mApV = 0; mActV = 0;
      beat = (cyc <= beatEnd);
      case (mState)
        0: if (cmdIn == ACT) mState = 1;
        1: begin
          if (cmdIn == ACT) mActV = 1;
          if (cmdIn == RD || cmdIn == WR) begin
            if (cmdIn == RD) begin
              beat = 1;
              beatEnd = full ? 32'h7fffffff : cyc + bl - 1;
            end else begin
              beat = 0;
              beatEnd = -1;
            end
            if (apReq && !full) begin
              len = (cmdIn == RD) ? bl : (blw - 1 + T_DPL);
              precAt = cyc + len;
              if (precAt == cyc + 1) begin
                mState = 3; idleAt = precAt + T_RP;
              end else begin
                mState = 2;
              end
            end
          end
          if (cmdIn == PRE) begin
            mState = 3; idleAt = cyc + 1 + T_RP; beat = 0; beatEnd = -1;
          end
          if (cmdIn == BST) begin
            beat = 0; beatEnd = -1;
          end
        end
        2: begin
          if (cmdIn >= RD && cmdIn <= BST) mApV = 1;
          if (cmdIn == ACT) mActV = 1;
          if (cyc + 1 == precAt) begin
            mState = 3; idleAt = precAt + T_RP;
          end
        end
        default: begin
          if (cmdIn == ACT) mActV = 1;
          if (cyc + 1 == idleAt) mState = 0;
        end
      endcase
      if (beat) dvAt[cyc + int'(casLat) + 1] = 1;
    end
    cyc++;
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (checking && !done) begin
      logic [7:0] expV, actV;
      bit dvExp;
      dvExp = dvAt.exists(cyc) ? dvAt[cyc] : 1'b0;
      expV = {mState[1:0], (mState == 1 || mState == 2), (mState == 3), (mState == 0),
              mApV, mActV, dvExp};
      actV = {bankState, bankOpen, precharging, actAllowed, apViolation, actViolation, rdDataValid};
      chk(curReq, 32'(actV), 32'(expV), "per-clock outputs vs model");
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(logic [2:0] c, logic a = 1'b0);
    cmdIn = c;
    apReq = a;
    @(negedge clk);
    cmdIn = NOP;
    apReq = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++;
    total++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    rst = 1'b1; cmdIn = NOP; apReq = 1'b0; burstSel = 3'd2; wrSingle = 1'b0; casLat = 2'd2;
    idle(3);
    // R1: reset state
    chk("R1", 32'(bankState), 0, "state after reset");
    chk("R1", 32'(actAllowed), 1, "actAllowed after reset");
    chk("R1", 32'({bankOpen, precharging, apViolation, actViolation, rdDataValid}), 0, "flags after reset");
    rst = 1'b0;
    checking = 1;

    // R13: commands ignored in IDLE
    curReq = "R13";
    issue(RD); issue(PRE); issue(BST); issue(WR, 1'b1);
    chk("R13", 32'({bankState, apViolation, actViolation}), 0, "idle ignores accesses");

    // R2: activate opens
    curReq = "R2";
    issue(ACT);
    chk("R2", 32'(bankState), 1, "state after activate");
    chk("R2", 32'(actAllowed), 0, "actAllowed while open");

    // R11: activate while open
    curReq = "R11";
    issue(ACT);
    chk("R11", 32'(actViolation), 1, "activate while open flagged");
    chk("R11", 32'(bankState), 1, "state kept on refused activate");

    // R12 + R3: BL4 read, CL2
    curReq = "R12";
    issue(RD);
    idle(1);
    chk("R12", 32'(rdDataValid), 0, "no data before CL+1");
    idle(1);
    chk("R12", 32'(rdDataValid), 1, "first beat at CL+1");
    idle(4);
    chk("R12", 32'(rdDataValid), 0, "window closed after 4 beats");
    curReq = "R3";
    chk("R3", 32'(bankState), 1, "open after plain read");
    issue(WR);
    idle(5);
    chk("R3", 32'(bankState), 1, "open after plain write");

    // R9: interruption of plain bursts
    curReq = "R9";
    burstSel = 3'd3;
    issue(RD); idle(2); issue(BST);
    idle(1);
    chk("R9", 32'(rdDataValid), 1, "last beat before stop");
    idle(1);
    chk("R9", 32'(rdDataValid), 0, "stop ends burst");
    issue(RD); issue(RD); idle(10);
    issue(RD); issue(WR); idle(6);

    // R12 with CL3
    curReq = "R12";
    casLat = 2'd3; burstSel = 3'd1;
    issue(RD);
    idle(2);
    chk("R12", 32'(rdDataValid), 0, "CL3 no data at clock 3");
    idle(1);
    chk("R12", 32'(rdDataValid), 1, "CL3 first beat at clock 4");
    idle(1);
    chk("R12", 32'(rdDataValid), 1, "CL3 second beat");
    idle(1);
    chk("R12", 32'(rdDataValid), 0, "CL3 window closed");
    casLat = 2'd2;
    idle(2);

    // R4 + R6: read with auto-precharge, BL2
    curReq = "R4";
    issue(RD, 1'b1);
    chk("R4", 32'(bankState), 2, "BURST_AP after read-AP");
    idle(1);
    chk("R4", 32'(bankState), 3, "precharge starts two clocks after read");
    curReq = "R6";
    idle(T_RP - 1);
    chk("R6", 32'({precharging, actAllowed}), 2, "still recovering at last tRP clock");
    idle(1);
    chk("R6", 32'({bankState, actAllowed}), 1, "IDLE after tRP");

    // R7 and R11 during precharge
    curReq = "R7";
    issue(ACT); issue(PRE);
    chk("R7", 32'(bankState), 3, "precharge command closes bank");
    curReq = "R11";
    issue(ACT);
    chk("R11", 32'({bankState, actViolation}), 7, "activate during recovery refused");
    curReq = "R7";
    idle(T_RP - 2);
    chk("R7", 32'(bankState), 3, "recovery lasts tRP");
    idle(1);
    chk("R7", 32'(bankState), 0, "idle after tRP");

    // R4: BL1 read with auto-precharge goes straight to precharge
    curReq = "R4";
    burstSel = 3'd0;
    issue(ACT); issue(RD, 1'b1);
    chk("R4", 32'(bankState), 3, "BL1 read-AP precharges next clock");
    idle(T_RP);

    // R5: BL4 write with auto-precharge
    curReq = "R5";
    burstSel = 3'd2;
    issue(ACT); issue(WR, 1'b1);
    idle(4 - 1 + T_DPL - 2);
    chk("R5", 32'(bankState), 2, "BURST_AP until tDPL after last data");
    idle(1);
    chk("R5", 32'(bankState), 3, "precharge starts after tDPL");
    idle(T_RP);
    chk("R5", 32'({bankState, actAllowed}), 1, "activate legal after tDAL");

    // R5: single write mode
    wrSingle = 1'b1; burstSel = 3'd3;
    issue(ACT); issue(WR, 1'b1);
    chk("R5", 32'(bankState), 2, "single write BURST_AP");
    idle(1);
    chk("R5", 32'(bankState), 3, "single write precharge after tDPL");
    idle(T_RP);
    wrSingle = 1'b0;

    // R8: commands during an auto-precharge burst
    curReq = "R8";
    burstSel = 3'd2;
    issue(ACT); issue(WR, 1'b1); issue(RD);
    chk("R8", 32'({bankState, apViolation}), 5, "read during AP burst flagged");
    issue(PRE);
    chk("R8", 32'({bankState, apViolation}), 5, "precharge during AP burst flagged");
    issue(BST);
    chk("R8", 32'(apViolation), 1, "burst stop during AP burst flagged");
    idle(T_RP + 4);
    chk("R8", 32'(bankState), 0, "AP burst completed normally");

    // R10: full page ignores auto-precharge
    curReq = "R10";
    burstSel = 3'd4;
    issue(ACT); issue(RD, 1'b1);
    chk("R10", 32'(bankState), 1, "full-page read-AP stays open");
    idle(20);
    chk("R10", 32'({bankState, rdDataValid}), 3, "full-page read still streaming");
    issue(BST);
    idle(4);
    chk("R10", 32'(rdDataValid), 0, "full-page read stopped");
    issue(WR, 1'b1);
    idle(3);
    chk("R10", 32'(bankState), 1, "full-page write-AP stays open");
    wrSingle = 1'b1;
    issue(WR, 1'b1);
    chk("R10", 32'(bankState), 1, "full page with single write ignores AP");
    wrSingle = 1'b0;
    issue(PRE);
    idle(T_RP + 2);

    finishRun();
  end

endmodule